// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models a single programmable logic cell. Two independent four-input lookup tables, here called F and G, each act as a 16-entry, 1-bit-wide read-only table addressed by their own four inputs. A third, three-input combining table H is addressed by the F result, the G result and one extra input. This lets the cell form any function of five inputs and some functions of up to nine. The cell has two combinational outputs. Each one carries either its own four-input table or the combining table.

Two storage flip-flops, X and Y, can each capture any of the three table results, or a direct input that bypasses the tables. Each flip-flop has its own clock-enable policy, set-or-clear choice for the asynchronous local control and power-on initial value. One bit chooses which clock edge is active for the whole cell. A global reset drives both flip-flops to their configured initial values.

All table contents and mode bits arrive through a one-bit serial shift port and are held in a configuration word. Every user output stays at zero until configuration has completed.

Top module: `cfg_logic_cell`

## Requirements
- R1: With the combinational output selects at 0, `x_comb` equals F-table bit number `f_in` and `y_comb` equals G-table bit number `g_in`. Input bit 0 is the least significant index bit.
- R2: The H table is indexed by `{h_in, g_result, f_result}`, so the index is h_in*4 + g*2 + f. Setting the X output select (mode bit 1) routes H to `x_comb`. Setting the Y output select (mode bit 2) routes H to `y_comb`.
- R3: The configuration word is 53 bits and is shifted in most significant bit first, one bit per rising `clk` edge while `cfg_en` is high. Bits 52..37 hold the F table, bits 36..21 the G table and bits 20..13 the H table. Bit k of each table is the output for index k. While `cfg_en` is low the word does not change.
- R4: After reset `cfg_done` is 0. It becomes 1 on the first rising edge with `cfg_en` low once at least 53 bits have been shifted in. It falls on the edge after `cfg_en` rises again, and counting then restarts. While `cfg_done` is 0, `x_comb`, `y_comb`, `qx` and `qy` are all 0.
- R5: Mode bit 7 (X) and bit 12 (Y) are the free-running enable bits. When that bit is 0, a flip-flop loads its data on the active edge only if `ce` is 1 and holds otherwise. When the bit is 1, the flip-flop loads on every active edge.
- R6: The data source field is bits 4:3 for X and bits 9:8 for Y. Code 0 selects F, 1 selects G, 2 selects H and 3 selects the direct input (`di_x` or `di_y`).
- R7: With mode bit 0 at 0 the flip-flops load on the rising `clk` edge. With mode bit 0 at 1 they load on the falling edge.
- R8: While `sr` is high, each flip-flop is forced at once, without waiting for a clock, to 1 if its set-select bit is 1 (bit 5 for X, bit 10 for Y) and to 0 otherwise. This overrides the clock and the enable.
- R9: While `gsr` is high, each flip-flop is forced at once to its initial value (bit 6 for X, bit 11 for Y). This overrides `sr`.
- R10: While `cfg_done` is 0 both flip-flops are held at their initial values. At the moment `cfg_done` rises, `qx` and `qy` show those values without any further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration and user flip-flops |
| rst_n | input | 1 | Synchronous active-low reset of the configuration logic |
| cfg_en | input | 1 | Shift enable for the configuration port |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| cfg_done | output | 1 | Configuration complete, user outputs live |
| f_in | input | 4 | Index inputs of the F table |
| g_in | input | 4 | Index inputs of the G table |
| h_in | input | 1 | Extra input of the H table |
| di_x | input | 1 | Direct data input to flip-flop X |
| di_y | input | 1 | Direct data input to flip-flop Y |
| ce | input | 1 | Clock enable for both flip-flops |
| sr | input | 1 | Local asynchronous set/clear, active high |
| gsr | input | 1 | Global asynchronous reset to initial values, active high |
| x_comb | output | 1 | Combinational X output (F or H) |
| y_comb | output | 1 | Combinational Y output (G or H) |
| qx | output | 1 | Registered output of flip-flop X |
| qy | output | 1 | Registered output of flip-flop Y |

## Verification
The riskiest overlaps are the asynchronous controls landing on an active clock edge, and `gsr` meeting `sr`. In the first case `sr` is held across edges while `ce` is high and the selected data differs from the forced value, and the bench confirms that the forced value survives the edge. In the second case `gsr` and `sr` are raised together with a set-select that disagrees with the initial value, so only the initial value counts as correct. A reload that begins while the cell is live is also provoked, and the outputs must drop to zero on the next edge.

// File: rtl/lcell_pkg.sv
// Package: shared sizes and the layout of the configuration word.
// Assumes the word is shifted MSB first, so the first field declared
// in cfg_t is the first to enter the cell.
package lcell_pkg;
    localparam int unsigned LUT_K   = 4;                 // inputs per main table
    localparam int unsigned CMB_K   = 3;                 // inputs of combining table
    localparam int unsigned LUT_W   = 1 << LUT_K;        // main table depth
    localparam int unsigned CMB_W   = 1 << CMB_K;        // combining table depth
    localparam int unsigned N_FF    = 2;                 // storage elements per cell

    // Data source of a storage element
    typedef enum logic [1:0] {
        DSRC_F      = 2'd0,
        DSRC_G      = 2'd1,
        DSRC_H      = 2'd2,
        DSRC_DIRECT = 2'd3
    } dsrc_e;

    // Per flip-flop mode bits (5 bits)
    typedef struct packed {
        logic  ce_free;     // ignore the clock enable
        logic  init_val;    // value after global reset / before config done
        logic  sr_is_set;   // local async control sets (1) or clears (0)
        dsrc_e dsrc;        // data source
    } ffmode_t;

    // Cell mode bits (13 bits)
    typedef struct packed {
        ffmode_t ff_y;
        ffmode_t ff_x;
        logic    y_from_h;  // y_comb carries H instead of G
        logic    x_from_h;  // x_comb carries H instead of F
        logic    clk_inv;   // flip-flops load on falling edge
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    // Whole configuration word
    typedef struct packed {
        logic [LUT_W-1:0] f_tab;
        logic [LUT_W-1:0] g_tab;
        logic [CMB_W-1:0] h_tab;
        mode_t            mode;
    } cfg_t;

    localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lcell_cfg_shift.sv
// Module: serial configuration store.
// Shifts one bit per rising edge while en is high, counts shifted bits
// (saturating at W) and raises done once en is low after a full word.
// Assumes rst_n is synchronous and active low.
module lcell_cfg_shift #(
    parameter int unsigned W = 53
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         done
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    logic [CNT_W-1:0] cnt;

    // Shift register, bit counter and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (en) begin
                word <= {word[W-2:0], din};
                if (done)
                    cnt <= CNT_W'(1);
                else if (cnt != CNT_FULL)
                    cnt <= cnt + CNT_W'(1);
            end
            done <= !en && (cnt == CNT_FULL);
        end
    end

    // The stored word only moves while shifting
    p_word_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(word));

    // Completion can only appear after a cycle with shifting stopped
    p_done_after_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!en));

    // A new load withdraws completion on the next edge
    p_done_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> !done);
endmodule

// File: rtl/lcell_lut.sv
// Module: N-input lookup table.
// The output is table bit number idx, so any N-input function can be
// stored. Purely combinational.
module lcell_lut #(
    parameter int unsigned N = 4
) (
    input  logic [(1<<N)-1:0] tab,
    input  logic [N-1:0]      idx,
    output logic              y
);
    // Table read
    always_comb y = tab[idx];
endmodule

// File: rtl/lcell_ff.sv
// Module: configurable storage element.
// Loads d on the rising edge of clk (the caller inverts clk for falling
// edge operation) when ce or ce_free is high. hold (global reset or not
// yet configured) forces init_val; sr forces sr_is_set. Both act
// asynchronously, and hold has priority over sr.
module lcell_ff
    import lcell_pkg::*;
(
    input  logic    clk,
    input  logic    hold,
    input  logic    sr,
    input  logic    ce,
    input  logic    d,
    input  ffmode_t m,
    output logic    q
);
    logic arst;

    // Combined asynchronous control
    always_comb arst = hold | sr;

    // Storage with asynchronous priority controls
    always_ff @(posedge clk or posedge arst) begin
        if (hold)
            q <= m.init_val;
        else if (sr)
            q <= m.sr_is_set;
        else if (ce || m.ce_free)
            q <= d;
    end
endmodule

// File: rtl/cfg_logic_cell.sv
// Module: configurable lookup-table logic cell (top).
// Holds a serially loaded configuration, evaluates F, G and the
// combining table H, and drives two configurable flip-flops. All user
// outputs are gated to zero until configuration completes.
module cfg_logic_cell
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_done,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    input  logic             di_x,
    input  logic             di_y,
    input  logic             ce,
    input  logic             sr,
    input  logic             gsr,
    output logic             x_comb,
    output logic             y_comb,
    output logic             qx,
    output logic             qy
);
    logic [CFG_W-1:0] cfg_word;
    cfg_t             cfg;
    logic             f_o, g_o, h_o;
    logic             uclk;
    logic             hold;
    logic [N_FF-1:0]  q_raw;
    logic [N_FF-1:0]  di;
    ffmode_t          ffm [N_FF];

    lcell_cfg_shift #(.W(CFG_W)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_en),
        .din  (cfg_din),
        .word (cfg_word),
        .done (cfg_done)
    );

    // Decode the configuration word into fields
    always_comb cfg = cfg_t'(cfg_word);

    lcell_lut #(.N(LUT_K)) u_lut_f (.tab(cfg.f_tab), .idx(f_in), .y(f_o));
    lcell_lut #(.N(LUT_K)) u_lut_g (.tab(cfg.g_tab), .idx(g_in), .y(g_o));
    lcell_lut #(.N(CMB_K)) u_lut_h (.tab(cfg.h_tab), .idx({h_in, g_o, f_o}), .y(h_o));

    // Cell clock polarity and flip-flop hold condition
    always_comb begin
        uclk = clk ^ cfg.mode.clk_inv;
        hold = gsr | !cfg_done;
    end

    // Per flip-flop mode and direct input
    always_comb begin
        ffm[0] = cfg.mode.ff_x;
        ffm[1] = cfg.mode.ff_y;
        di     = {di_y, di_x};
    end

    for (genvar i = 0; i < N_FF; i++) begin : g_ff
        logic d_sel;

        // Data source selection
        always_comb begin
            case (ffm[i].dsrc)
                DSRC_F:  d_sel = f_o;
                DSRC_G:  d_sel = g_o;
                DSRC_H:  d_sel = h_o;
                default: d_sel = di[i];
            endcase
        end

        lcell_ff u_ff (
            .clk (uclk),
            .hold(hold),
            .sr  (sr),
            .ce  (ce),
            .d   (d_sel),
            .m   (ffm[i]),
            .q   (q_raw[i])
        );

        // Global reset held across an edge leaves the initial value
        p_gsr_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_done && gsr && $past(gsr)) |-> (q_raw[i] == ffm[i].init_val));

        // Local control held across an edge leaves the set/clear value
        p_sr_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_done && sr && $past(sr) && !gsr && !$past(gsr))
            |-> (q_raw[i] == ffm[i].sr_is_set));
    end

    // Output routing and gating until configured
    always_comb begin
        x_comb = cfg_done & (cfg.mode.x_from_h ? h_o : f_o);
        y_comb = cfg_done & (cfg.mode.y_from_h ? h_o : g_o);
        qx     = cfg_done & q_raw[0];
        qy     = cfg_done & q_raw[1];
    end
endmodule

// File: tb/test_cfg_logic_cell.sv
// Directed bench: one task per scenario, each checking its own results.
module test_cfg_logic_cell;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic h_in = 0, di_x = 0, di_y = 0, ce = 0, sr = 0, gsr = 0;
    logic cfg_done, x_comb, y_comb, qx, qy;
    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_logic_cell i_cfg_logic_cell (.*);

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Mode word: {ceY,initY,setY,srcY[1:0],ceX,initX,setX,srcX[1:0],yH,xH,inv}
    function automatic logic [12:0] mk_mode(logic inv, logic xh, logic yh,
            logic [1:0] sx, logic stx, logic ix, logic cx,
            logic [1:0] sy, logic sty, logic iy, logic cy);
        return {cy, iy, sty, sy, cx, ix, stx, sx, yh, xh, inv};
    endfunction

    task automatic load_cfg(logic [15:0] ft, logic [15:0] gt, logic [7:0] ht, logic [12:0] md);
        logic [52:0] w;
        w = {ft, gt, ht, md};
        for (int i = 52; i >= 0; i--) begin
            cfg_en = 1'b1; cfg_din = w[i]; tick();
        end
        cfg_en = 1'b0; cfg_din = 1'b0; tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        chk("R4 done after reset", cfg_done, 1'b0);
        chk("R4 x_comb gated", x_comb, 1'b0);
        chk("R4 qx gated", qx, 1'b0);
        chk("R4 qy gated", qy, 1'b0);
        // a short word must not complete the load
        for (int i = 0; i < 10; i++) begin cfg_en = 1'b1; cfg_din = 1'b1; tick(); end
        cfg_en = 1'b0; tick();
        chk("R4 partial load not done", cfg_done, 1'b0);
    endtask

    task automatic t_tables();
        for (int r = 0; r < 3; r++) begin
            logic [15:0] ft, gt; logic [7:0] ht;
            ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
            load_cfg(ft, gt, ht, mk_mode(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            chk("R4 done after load", cfg_done, 1'b1);
            for (int i = 0; i < 16; i++) begin
                f_in = 4'(i); g_in = ~4'(i); #1;
                chk("R1/R3 F table", x_comb, ft[i]);
                chk("R1/R3 G table", y_comb, gt[15-i]);
            end
            tick();
            load_cfg(ft, gt, ht, mk_mode(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
            for (int k = 0; k < 512; k++) begin
                logic e;
                f_in = k[3:0]; g_in = k[7:4]; h_in = k[8]; #1;
                e = ht[{k[8], gt[k[7:4]], ft[k[3:0]]}];
                chk("R2/R3 H via x", x_comb, e);
                chk("R2/R3 H via y", y_comb, e);
            end
            tick();
        end
    endtask

    task automatic t_gate();
        f_in = 4'd5; g_in = 4'd9;
        load_cfg(16'hFFFF, 16'hFFFF, 8'h00, mk_mode(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R1 all-ones F", x_comb, 1'b1);
        cfg_en = 1'b1; cfg_din = 1'b1; tick();
        chk("R4 done drops on reload", cfg_done, 1'b0);
        chk("R4 x gated on reload", x_comb, 1'b0);
        chk("R4 y gated on reload", y_comb, 1'b0);
        load_cfg(16'hFFFF, 16'hFFFF, 8'h00, mk_mode(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R4 done after reload", cfg_done, 1'b1);
        chk("R4 x live after reload", x_comb, 1'b1);
    endtask

    task automatic t_capture();
        for (int s = 0; s < 4; s++) begin
            load_cfg(16'hAAAA, 16'hCCCC, 8'hF0,
                     mk_mode(0, 0, 0, 2'(s), 0, 0, 0, 2'(s), 0, 0, 1));
            f_in = (s == 0) ? 4'd1 : 4'd0; g_in = (s == 1) ? 4'd2 : 4'd0;
            h_in = (s == 2); di_x = (s == 3); di_y = (s == 3); ce = 1'b1;
            tick();
            chk("R6 source to X", qx, 1'b1);
            chk("R6 source to Y", qy, 1'b1);
            f_in = 0; g_in = 0; h_in = 0; di_x = 0; di_y = 0; ce = 1'b0;
            tick();
            chk("R5 X holds with ce low", qx, 1'b1);
            chk("R5 Y free enable loads", qy, 1'b0);
            ce = 1'b1; tick();
            chk("R5 X loads with ce high", qx, 1'b0);
        end
        ce = 1'b0;
    endtask

    task automatic t_polarity();
        for (int inv = 0; inv < 2; inv++) begin
            load_cfg(16'h0, 16'h0, 8'h0, mk_mode(1'(inv), 0, 0, 3, 0, 0, 1, 3, 0, 0, 1));
            di_x = 1'b0; tick(); tick();
            di_x = 1'b1; #4;
            chk("R7 state after falling edge", qx, 1'(inv));
            tick();
            chk("R7 state after rising edge", qx, 1'b1);
        end
        di_x = 1'b0;
    endtask

    task automatic t_sr();
        load_cfg(16'h0, 16'h0, 8'h0, mk_mode(0, 0, 0, 3, 1, 0, 1, 3, 0, 0, 1));
        di_x = 1'b0; di_y = 1'b1; tick();
        chk("R5 X loads direct 0", qx, 1'b0);
        chk("R5 Y loads direct 1", qy, 1'b1);
        sr = 1'b1; #1;
        chk("R8 X set without edge", qx, 1'b1);
        chk("R8 Y clear without edge", qy, 1'b0);
        tick();
        chk("R8 X set overrides edge", qx, 1'b1);
        chk("R8 Y clear overrides edge", qy, 1'b0);
        sr = 1'b0; tick();
        chk("R8 X normal after release", qx, 1'b0);
        chk("R8 Y normal after release", qy, 1'b1);
        di_y = 1'b0;
    endtask

    task automatic t_gsr();
        di_x = 1'b0; di_y = 1'b1;
        load_cfg(16'h0, 16'h0, 8'h0, mk_mode(0, 0, 0, 3, 0, 1, 1, 3, 1, 0, 1));
        chk("R10 X init at done", qx, 1'b1);
        chk("R10 Y init at done", qy, 1'b0);
        di_x = 1'b0; di_y = 1'b1; tick();
        chk("R9 X loads before gsr", qx, 1'b0);
        chk("R9 Y loads before gsr", qy, 1'b1);
        gsr = 1'b1; sr = 1'b1; #1;
        chk("R9 X init beats sr", qx, 1'b1);
        chk("R9 Y init beats sr", qy, 1'b0);
        tick();
        chk("R9 X init held over edge", qx, 1'b1);
        chk("R9 Y init held over edge", qy, 1'b0);
        gsr = 1'b0; sr = 1'b0; tick();
        chk("R9 X normal after gsr", qx, 1'b0);
        chk("R9 Y normal after gsr", qy, 1'b1);
        di_y = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_tables();
        t_gate();
        t_capture();
        t_polarity();
        t_sr();
        t_gsr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule